// File: doc/BRIEF.md
# Accumulator Machine with Memory Skip and Microoperations

This block is a small processor core that executes one instruction per clock cycle. Its state is a program counter, an accumulator, an auxiliary register and a 32-word internal data memory. Instructions come from an external port with a valid strobe. The program counter is an output: the surrounding logic uses it to pick the next word to present. The core reads a memory word, changes it and writes it back in the same cycle. It can skip the following instruction on a zero result. A combined microoperation opcode can increment the accumulator, test it for zero and swap it with the auxiliary register, all in one step.

A separate preload port fills the memory while no instruction is being presented. A combinational peek port reads any memory word without disturbing execution.

Top module: `acc_machine`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets pc, ac and ax to zero. It leaves the memory contents unchanged, and no instruction executes in that cycle.
- R2: The instruction word is 11 bits wide. Bits [10:8] hold the opcode, bits [7:3] the word address A, bit 2 flag F0, bit 1 flag F1 and bit 0 flag F2. An instruction executes only at a clock edge where instr_valid is high. When it is low, pc, ac and ax hold.
- R3: Opcode 0 adds the memory word at A to ac, modulo 256, and advances pc by one.
- R4: Opcode 1 writes ac into the memory word at A, clears ac to zero and advances pc by one.
- R5: Opcode 2 writes the memory word at A plus one, modulo 256, back to A. pc advances by two when the new value is zero, and by one otherwise.
- R6: Opcode 3 loads pc with A and leaves ac, ax and the memory unchanged.
- R7: Opcode 7 with F0 set increments ac, modulo 256.
- R8: Opcode 7 with F1 set advances pc by two when ac is zero after any F0 increment in the same instruction, and by one otherwise.
- R9: Opcode 7 with F2 set swaps ac and ax. The swap is applied last, so ax receives the incremented value when F0 is also set.
- R10: Opcode 7 with all flags clear, and opcodes 4, 5 and 6, change nothing except advancing pc by one.
- R11: When load_we is high at a clock edge where instr_valid is low, load_data is written to the word at load_addr. When instr_valid is high, load_we has no effect.
- R12: peek_data always shows the current content of the memory word at peek_addr, without a clock cycle of delay.
- R13: pc is 5 bits wide and wraps modulo 32 for both single and double steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Execute instr at this edge |
| instr | input | 11 | Instruction word {op, A, F0, F1, F2} |
| load_we | input | 1 | Preload write strobe, honoured only when idle |
| load_addr | input | 5 | Preload word address |
| load_data | input | 8 | Preload data |
| peek_addr | input | 5 | Memory read address for observation |
| peek_data | output | 8 | Memory word at peek_addr |
| pc | output | 5 | Program counter |
| ac | output | 8 | Accumulator |
| ax | output | 8 | Auxiliary register |

## Verification
The directed patterns drive the memory increment across 255 to 0 and also a plain increment, which separates the skip step from the plain step. They run the microoperation with ac at 255 and F0 plus F1 set, which shows whether the zero test looks at ac before or after the increment. F0 combined with F2 shows whether the swap comes last. Jumps near the top of the address space, followed by skips, show the program counter wrapping. Preload strobes during execution, and a reset in the middle of a run followed by a full memory read, show that those stimuli leave the memory alone. A long run of random instructions, idle cycles and preloads is then compared against a behavioural model on every clock.

// File: rtl/am_pkg.sv
package am_pkg;
    parameter int OP_W   = 3;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 8;
    localparam int FLAG_W  = 3;
    localparam int INSTR_W = OP_W + ADDR_W + FLAG_W;
    localparam int WORDS   = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD  = 3'd0,
        OPC_STZ  = 3'd1,
        OPC_ISZ  = 3'd2,
        OPC_JMP  = 3'd3,
        OPC_RSV4 = 3'd4,
        OPC_RSV5 = 3'd5,
        OPC_RSV6 = 3'd6,
        OPC_UOP  = 3'd7
    } opcode_e;

    // field layout of the instruction word (R2)
    typedef struct packed {
        opcode_e             op;
        logic [ADDR_W-1:0]   addr;
        logic                f_inc;
        logic                f_skz;
        logic                f_swp;
    } instr_t;

    typedef struct packed {
        logic                do_add;
        logic                do_stz;
        logic                do_isz;
        logic                do_jmp;
        logic                do_uop;
        logic [ADDR_W-1:0]   addr;
        logic                f_inc;
        logic                f_skz;
        logic                f_swp;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   ac;
        logic [DATA_W-1:0]   ax;
    } arch_t;
endpackage

// File: rtl/am_decode.sv
module am_decode
    import am_pkg::*;
(
    input  logic               run,
    input  logic [INSTR_W-1:0] instr,
    output ctl_t               ctl
);
    instr_t iw;

    always_comb begin
        iw = instr_t'(instr);
        ctl = '0;
        ctl.addr  = iw.addr;
        ctl.f_inc = iw.f_inc;
        ctl.f_skz = iw.f_skz;
        ctl.f_swp = iw.f_swp;
        if (run) begin
            unique case (iw.op)
                OPC_ADD: ctl.do_add = 1'b1;
                OPC_STZ: ctl.do_stz = 1'b1;
                OPC_ISZ: ctl.do_isz = 1'b1;
                OPC_JMP: ctl.do_jmp = 1'b1;
                OPC_UOP: ctl.do_uop = 1'b1;
                OPC_RSV4, OPC_RSV5, OPC_RSV6: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/am_exec.sv
module am_exec
    import am_pkg::*;
(
    input  ctl_t               ctl,
    input  arch_t              cur,
    input  logic [DATA_W-1:0]  mem_rd,
    output logic [DATA_W-1:0]  ac_d,
    output logic [DATA_W-1:0]  ax_d,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wd,
    output logic               skip,
    output logic               jump
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] mem_inc_w;
    logic [DATA_W-1:0] ac_inc_w;

    always_comb begin
        sum_w     = cur.ac + mem_rd;
        mem_inc_w = mem_rd + DATA_W'(1);
        ac_inc_w  = ctl.f_inc ? cur.ac + DATA_W'(1) : cur.ac;

        ac_d   = cur.ac;
        ax_d   = cur.ax;
        mem_we = 1'b0;
        mem_wd = '0;
        skip   = 1'b0;
        jump   = ctl.do_jmp;

        if (ctl.do_add) begin
            ac_d = sum_w;
        end
        if (ctl.do_stz) begin
            mem_we = 1'b1;
            mem_wd = cur.ac;
            ac_d   = '0;
        end
        if (ctl.do_isz) begin
            mem_we = 1'b1;
            mem_wd = mem_inc_w;
            skip   = (mem_inc_w == '0);
        end
        if (ctl.do_uop) begin
            // increment, then zero test, then swap
            skip = ctl.f_skz && (ac_inc_w == '0);
            if (ctl.f_swp) begin
                ac_d = cur.ax;
                ax_d = ac_inc_w;
            end else begin
                ac_d = ac_inc_w;
            end
        end
    end
endmodule

// File: rtl/am_pcseq.sv
module am_pcseq
    import am_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_q,
    input  logic              jump,
    input  logic              skip,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_d
);
    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

    always_comb begin
        if (jump)
            pc_d = target;
        else
            pc_d = pc_q + (skip ? STEP_TWO : STEP_ONE);
    end
endmodule

// File: rtl/am_wordmem.sv
module am_wordmem #(
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int NW = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] words [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [DW-1:0] cell_d;
        logic [DW-1:0] cell_q;

        always_comb begin
            cell_d = cell_q;
            if (we && (waddr == AW'(w)))
                cell_d = wdata;
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign words[w] = cell_q;
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/acc_machine.sv
module acc_machine
    import am_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               load_we,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [DATA_W-1:0]  load_data,
    input  logic [ADDR_W-1:0]  peek_addr,
    output logic [DATA_W-1:0]  peek_data,
    output logic [ADDR_W-1:0]  pc,
    output logic [DATA_W-1:0]  ac,
    output logic [DATA_W-1:0]  ax
);
    arch_t             st_d, st_q;
    ctl_t              ctl;
    logic              run;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] exe_ac, exe_ax, exe_wd;
    logic              exe_we, exe_skip, exe_jump;
    logic [ADDR_W-1:0] exe_pc;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;

    assign run = instr_valid && rst_n;

    am_decode u_dec (
        .run   (run),
        .instr (instr),
        .ctl   (ctl)
    );

    am_exec u_exe (
        .ctl    (ctl),
        .cur    (st_q),
        .mem_rd (mem_rd),
        .ac_d   (exe_ac),
        .ax_d   (exe_ax),
        .mem_we (exe_we),
        .mem_wd (exe_wd),
        .skip   (exe_skip),
        .jump   (exe_jump)
    );

    am_pcseq u_pcs (
        .pc_q   (st_q.pc),
        .jump   (exe_jump),
        .skip   (exe_skip),
        .target (ctl.addr),
        .pc_d   (exe_pc)
    );

    // execution owns the write port while an instruction is presented
    always_comb begin
        if (run) begin
            mem_we = exe_we;
            mem_wa = ctl.addr;
            mem_wd = exe_wd;
        end else begin
            mem_we = load_we && !instr_valid;
            mem_wa = load_addr;
            mem_wd = load_data;
        end
    end

    am_wordmem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_wa),
        .wdata   (mem_wd),
        .raddr_a (ctl.addr),
        .rdata_a (mem_rd),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (instr_valid) begin
            st_d.pc = exe_pc;
            st_d.ac = exe_ac;
            st_d.ax = exe_ax;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;
    assign ac = st_q.ac;
    assign ax = st_q.ax;
endmodule

// File: rtl/am_checker.sv
module am_checker
    import am_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  pc,
    input logic [DATA_W-1:0]  ac,
    input logic [DATA_W-1:0]  ax
);
    logic [OP_W-1:0]   op_w;
    logic [ADDR_W-1:0] a_w;
    logic              f0_w, f1_w, f2_w;

    assign op_w = instr[INSTR_W-1 -: OP_W];
    assign a_w  = instr[FLAG_W +: ADDR_W];
    assign f0_w = instr[2];
    assign f1_w = instr[1];
    assign f2_w = instr[0];

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && ac == '0 && ax == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc) && $stable(ac) && $stable(ax)));

    p_store_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w == 3'd1) |=> (ac == '0 && $stable(ax)));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w == 3'd3) |=>
            (pc == $past(a_w) && $stable(ac) && $stable(ax)));

    p_uop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w == 3'd7 && f0_w && !f2_w) |=>
            (ac == DATA_W'($past(ac) + DATA_W'(1))));

    p_uop_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w == 3'd7 && f1_w && !f0_w && ac == '0) |=>
            (pc == ADDR_W'($past(pc) + ADDR_W'(2))));

    p_uop_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w == 3'd7 && f2_w && !f0_w) |=>
            (ac == $past(ax) && ax == $past(ac)));

    p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (op_w inside {3'd4, 3'd5, 3'd6} ||
                         (op_w == 3'd7 && !f0_w && !f1_w && !f2_w))) |=>
            (pc == ADDR_W'($past(pc) + ADDR_W'(1)) && $stable(ac) && $stable(ax)));

    p_pc_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op_w != 3'd3) |=>
            (pc == ADDR_W'($past(pc) + ADDR_W'(1)) ||
             pc == ADDR_W'($past(pc) + ADDR_W'(2))));
endmodule

bind acc_machine am_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pc          (pc),
    .ac          (ac),
    .ax          (ax)
);

// File: tb/sim_acc_machine.sv
`timescale 1ns/1ps
module sim_acc_machine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [10:0] instr = '0;
    logic        load_we = 1'b0;
    logic [4:0]  load_addr = '0;
    logic [7:0]  load_data = '0;
    logic [4:0]  peek_addr = '0;
    logic [7:0]  peek_data;
    logic [4:0]  pc;
    logic [7:0]  ac;
    logic [7:0]  ax;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int m_mem [32];
    int m_pc, m_ac, m_ax;

    always #4 clk = ~clk;

    acc_machine u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .pc(pc), .ac(ac), .ax(ax)
    );

    function automatic logic [10:0] mk(int op, int a, bit f0, bit f1, bit f2);
        return {3'(op), 5'(a), f0, f1, f2};
    endfunction

    function automatic string tag_of(bit v, logic [10:0] ins);
        if (!v) return "R2/R11";
        case (ins[10:8])
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd7: begin
                if (ins[0]) return "R9";
                if (ins[1]) return "R8";
                if (ins[2]) return "R7";
                return "R10";
            end
            default: return "R10";
        endcase
    endfunction

    task automatic check_state(string tag);
        checks++;
        if (int'(pc) != m_pc || int'(ac) != m_ac || int'(ax) != m_ax) begin
            failures++;
            $display("FAIL %s: pc/ac/ax actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, pc, ac, ax, m_pc, m_ac, m_ax);
        end
    endtask

    task automatic model_exec(logic [10:0] ins);
        int op = int'(ins[10:8]);
        int a  = int'(ins[7:3]);
        int t;
        case (op)
            0: begin m_ac = (m_ac + m_mem[a]) % 256; m_pc = (m_pc + 1) % 32; end
            1: begin m_mem[a] = m_ac; m_ac = 0; m_pc = (m_pc + 1) % 32; end
            2: begin
                m_mem[a] = (m_mem[a] + 1) % 256;
                m_pc = (m_pc + ((m_mem[a] == 0) ? 2 : 1)) % 32;
            end
            3: m_pc = a;
            7: begin
                t = ins[2] ? (m_ac + 1) % 256 : m_ac;
                m_pc = (m_pc + ((ins[1] && t == 0) ? 2 : 1)) % 32;
                if (ins[0]) begin m_ac = m_ax; m_ax = t; end
                else m_ac = t;
            end
            default: m_pc = (m_pc + 1) % 32;
        endcase
    endtask

    task automatic step(bit v, logic [10:0] ins, bit lwe, int la, int ld);
        @(negedge clk);
        instr_valid = v;
        instr       = ins;
        load_we     = lwe;
        load_addr   = 5'(la);
        load_data   = 8'(ld);
        @(posedge clk);
        if (v) model_exec(ins);
        else if (lwe) m_mem[la] = ld % 256;
        #2;
        check_state(tag_of(v, ins));
    endtask

    task automatic run_i(logic [10:0] ins);
        step(1'b1, ins, 1'b0, 0, 0);
    endtask

    task automatic sweep(string tag);
        @(negedge clk);
        instr_valid = 1'b0;
        load_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            peek_addr = 5'(i);
            #0.1;
            checks++;
            if (int'(peek_data) != m_mem[i]) begin
                failures++;
                $display("FAIL %s: mem[%0d] actual %0d expected %0d",
                         tag, i, peek_data, m_mem[i]);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b1;
        instr = mk(1, 3, 0, 0, 0);
        repeat (2) @(posedge clk);
        m_pc = 0; m_ac = 0; m_ax = 0;
        #2;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        instr_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 0;
        m_pc = 0; m_ac = 0; m_ax = 0;
        // preload during reset, then check reset state
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = 5'(i); load_data = 8'(i * 7 + 3);
            @(posedge clk);
            m_mem[i] = (i * 7 + 3) % 256;
        end
        @(negedge clk);
        load_we = 1'b0;
        #2;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R11/R12");

        step(1'b0, '0, 1'b1, 12, 255);                // R11 idle write
        step(1'b0, '0, 1'b1, 20, 255);
        step(1'b0, '0, 1'b0, 0, 0);                   // R2 idle hold
        run_i(mk(0, 2, 0, 0, 0));                     // R3 add 17
        run_i(mk(0, 20, 0, 0, 0));                    // R3 wrap 17+255
        run_i(mk(1, 10, 0, 0, 0));                    // R4 store and clear
        run_i(mk(2, 12, 0, 0, 0));                    // R5 255->0 skip
        run_i(mk(2, 13, 0, 0, 0));                    // R5 no skip
        run_i(mk(3, 30, 0, 0, 0));                    // R6 jump
        run_i(mk(4, 0, 0, 0, 0));                     // R10/R13 30->31
        run_i(mk(5, 0, 0, 0, 0));                     // R13 31->0
        run_i(mk(3, 31, 0, 0, 0));
        run_i(mk(7, 0, 0, 1, 0));                     // R8 ac=0 skip, wrap to 1
        run_i(mk(0, 20, 0, 0, 0));                    // ac=255
        run_i(mk(7, 0, 1, 1, 0));                     // R7/R8 inc to 0 then skip
        run_i(mk(7, 0, 1, 0, 0));                     // R7 ac=1
        run_i(mk(7, 0, 0, 1, 0));                     // R8 nonzero no skip
        run_i(mk(7, 0, 0, 0, 1));                     // R9 swap
        run_i(mk(7, 0, 1, 0, 1));                     // R9 inc then swap
        run_i(mk(7, 0, 1, 1, 1));                     // R9 all three
        run_i(mk(7, 0, 0, 0, 0));                     // R10 no flags
        run_i(mk(6, 9, 1, 1, 1));                     // R10 opcode 6
        step(1'b1, mk(3, 5, 0, 0, 0), 1'b1, 5, 170);  // R11 load ignored
        step(1'b1, mk(0, 5, 0, 0, 0), 1'b1, 6, 85);   // R11 load ignored
        sweep("R11/R4/R5");

        run_i(mk(0, 7, 0, 0, 0));
        do_reset();                                   // R1 mid-run
        sweep("R1");

        for (int n = 0; n < 1500; n++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 8)
                run_i(11'($urandom));
            else
                step(1'b0, 11'($urandom), 1'(r == 9),
                     int'($urandom_range(0, 31)), int'($urandom_range(0, 255)));
        end
        sweep("R3/R4/R5/R11");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule